// File: doc/BRIEF.md
# Two-Byte Write-Only I2C Slave Receiver

This block sits on a two-wire I2C bus as a receive-only slave. It oversamples SCL and SDA on a fast system clock, finds START and STOP conditions, and collects one address byte followed by a most-significant and a least-significant data byte. It acknowledges each accepted byte by pulling SDA low through an open-drain control output. Each data byte is copied into its own output register during its acknowledge clock, and a one-cycle strobe marks each update.

The 7-bit slave address has a fixed six-bit prefix (default 001011). Its last bit is the inverse of a strap input, so one part can answer at either of two addresses. A transfer that names another address, or that asks to read, is left alone until the next START or STOP. The system clock must run at least eight times faster than SCL.

Top module: `i2cw_word_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START and restarts address reception from any state. A rising SDA while SCL is high is a STOP; it returns the receiver to idle and releases SDA.
- R2: The address byte is shifted in MSB first: seven address bits, then the direction bit. The byte is acknowledged only when the address equals {prefix, ~strap} and the direction bit is 0. With the default prefix, strap 0 selects 0010111 and strap 1 selects 0010110.
- R3: If the address does not match, or the direction bit is 1, there is no acknowledge. SDA stays released and the registers stay unchanged until the next START or STOP.
- R4: The slave pulls SDA low only while SCL is low, starting after the falling edge that ends the eighth bit. It holds SDA low through the whole high period of the ninth clock and releases it at the falling edge of that clock.
- R5: The first data byte after an accepted address is acknowledged. It is copied to the MS output register during its acknowledge clock, with a one-cycle MS strobe.
- R6: The second data byte is acknowledged. It is copied to the LS output register during its acknowledge clock, with a one-cycle LS strobe. A register does not change in a cycle where its strobe is low.
- R7: A byte that is cut short by a START or STOP before its eighth bit is discarded, and no register is updated.
- R8: Bytes that follow the LS byte before a STOP are not acknowledged and leave both registers and strobes unchanged.
- R9: After reset, both byte registers are 0, both strobes are low and SDA is released.
- R10: Data bits are taken MSB first, one per SCL rising edge, so the first bit sent lands in bit 7 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| strap_i | input | 1 | Address select; address LSB is its inverse |
| sda_pull_o | output | 1 | 1 = drive SDA low (open drain), 0 = release |
| ms_byte_o | output | 8 | Latched most-significant data byte |
| ls_byte_o | output | 8 | Latched least-significant data byte |
| ms_upd_o | output | 1 | One-cycle pulse when ms_byte_o is updated |
| ls_upd_o | output | 1 | One-cycle pulse when ls_byte_o is updated |

## Verification
The hardest case to reach from the ports is a byte that breaks off partway, with a STOP or a repeated START cut into the middle of a data byte after a good address has already been acknowledged. Only then is the discard path taken instead of the latch path. The bench models an open-drain bus master that can issue any number of bits before forcing a condition. Directed cases cut the MS and LS bytes short. Random transfers vary the address, the direction bit, the strap value and the number of trailing extra bytes.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_IGNORE
  } rx_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_MS,
    PH_LS,
    PH_EXTRA
  } phase_e;

  // address this slave answers to: fixed prefix, LSB is inverted strap
  function automatic logic [ADDR_W-1:0] own_address(
    input logic [ADDR_W-2:0] prefix,
    input logic              strap
  );
    return {prefix, ~strap};
  endfunction

  // first byte carries address in [7:1] and direction in [0] (0 = write)
  function automatic logic addr_hit(
    input logic [BYTE_W-1:0] first_byte,
    input logic [ADDR_W-1:0] own
  );
    return (first_byte[BYTE_W-1:BYTE_W-ADDR_W] == own) && !first_byte[0];
  endfunction

  function automatic phase_e next_phase(input phase_e ph);
    case (ph)
      PH_ADDR: return PH_MS;
      PH_MS:   return PH_LS;
      default: return PH_EXTRA;
    endcase
  endfunction
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES < 2) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cw_bus_events.sv
module i2cw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  logic scl_steady_high;
  assign scl_steady_high = scl_s && scl_q;
  assign scl_rise  = scl_s && !scl_q;
  assign scl_fall  = !scl_s && scl_q;
  assign start_evt = scl_steady_high && sda_q && !sda_s;
  assign stop_evt  = scl_steady_high && !sda_q && sda_s;
endmodule

// File: rtl/i2cw_rx_fsm.sv
module i2cw_rx_fsm
  import i2cw_pkg::*;
#(
  parameter logic [ADDR_W-2:0] ADDR_PREFIX = 6'b001011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_high,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_bit,
  input  logic              strap,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] ms_byte,
  output logic [BYTE_W-1:0] ls_byte,
  output logic              ms_upd,
  output logic              ls_upd
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  rx_state_e         state;
  phase_e            phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              byte_full;

  // named internal events for the checks
  logic [ADDR_W-1:0] own_addr;
  logic              take_bit;
  logic              byte_decide;
  logic              ack_high_edge;
  logic              ack_end;
  assign own_addr      = own_address(ADDR_PREFIX, strap);
  assign take_bit      = (state == ST_RECV) && scl_rise && !byte_full;
  assign byte_decide   = (state == ST_RECV) && scl_fall && byte_full;
  assign ack_high_edge = (state == ST_ACK) && scl_rise;
  assign ack_end       = (state == ST_ACK) && scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= PH_ADDR;
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_full <= 1'b0;
      sda_pull  <= 1'b0;
      ms_byte   <= '0;
      ls_byte   <= '0;
      ms_upd    <= 1'b0;
      ls_upd    <= 1'b0;
    end else begin
      ms_upd <= 1'b0;
      ls_upd <= 1'b0;
      if (start_evt) begin
        state     <= ST_RECV;
        phase     <= PH_ADDR;
        bit_cnt   <= '0;
        byte_full <= 1'b0;
        sda_pull  <= 1'b0;
      end else if (stop_evt) begin
        state     <= ST_IDLE;
        phase     <= PH_ADDR;
        bit_cnt   <= '0;
        byte_full <= 1'b0;
        sda_pull  <= 1'b0;
      end else begin
        if (take_bit) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_bit};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) byte_full <= 1'b1;
        end
        if (byte_decide) begin
          byte_full <= 1'b0;
          bit_cnt   <= '0;
          case (phase)
            PH_ADDR: begin
              if (addr_hit(shreg, own_addr)) begin
                state    <= ST_ACK;
                sda_pull <= 1'b1;
              end else begin
                state <= ST_IGNORE;
              end
            end
            PH_MS, PH_LS: begin
              state    <= ST_ACK;
              sda_pull <= 1'b1;
            end
            default: state <= ST_ACK;  // extra byte: ninth clock, no pull
          endcase
        end
        if (ack_high_edge) begin
          if (phase == PH_MS) begin
            ms_byte <= shreg;
            ms_upd  <= 1'b1;
          end
          if (phase == PH_LS) begin
            ls_byte <= shreg;
            ls_upd  <= 1'b1;
          end
        end
        if (ack_end) begin
          sda_pull <= 1'b0;
          state    <= ST_RECV;
          phase    <= next_phase(phase);
        end
      end
    end
  end

  // R4: the pull-down only starts while SCL is low
  assert_pull_starts_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_high);
  // R4: the pull-down is released on the ninth falling edge
  assert_release_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull && scl_fall && !start_evt && !stop_evt) |=> !sda_pull);
  // R1: STOP leaves the receiver idle with SDA released
  assert_stop_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE) && !sda_pull);
  // R3: no acknowledge while ignoring the bus
  assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_pull && !ms_upd && !ls_upd);
  // R6: registers change only with their strobe; strobes last one cycle
  assert_ms_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_upd |-> $stable(ms_byte));
  assert_ls_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_upd |-> $stable(ls_byte));
  assert_strobe_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_upd || ls_upd) |=> !ms_upd && !ls_upd);
  // R8: no acknowledge of trailing bytes
  assert_extra_no_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXTRA) |-> !sda_pull);
endmodule

// File: rtl/i2cw_word_slave.sv
module i2cw_word_slave
  import i2cw_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-2:0] ADDR_PREFIX = 6'b001011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] ms_byte_o,
  output logic [BYTE_W-1:0] ls_byte_o,
  output logic              ms_upd_o,
  output logic              ls_upd_o
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  i2cw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
  );
  i2cw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
  );

  i2cw_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cw_rx_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_high(scl_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .sda_bit(sda_s), .strap(strap_i),
    .sda_pull(sda_pull_o), .ms_byte(ms_byte_o), .ls_byte(ls_byte_o),
    .ms_upd(ms_upd_o), .ls_upd(ls_upd_o)
  );
endmodule

// File: tb/i2cw_word_slave_tb.sv
module i2cw_word_slave_tb;
  localparam int Q = 8;  // system cycles per SCL quarter period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, strap = 1'b0;
  logic sda_pull, ms_upd, ls_upd;
  logic [7:0] ms_byte, ls_byte;
  logic sda_line;
  assign sda_line = m_sda & ~sda_pull;

  always #4 clk = ~clk;  // 125 MHz

  i2cw_word_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(strap), .sda_pull_o(sda_pull),
    .ms_byte_o(ms_byte), .ls_byte_o(ls_byte),
    .ms_upd_o(ms_upd), .ls_upd_o(ls_upd)
  );

  int total = 0, bad = 0;
  int ms_cnt = 0, ls_cnt = 0;
  int exp_ms_cnt = 0, exp_ls_cnt = 0;
  logic [7:0] exp_ms = 8'h00, exp_ls = 8'h00;
  bit finished = 0;

  always @(posedge clk) begin
    if (ms_upd) ms_cnt <= ms_cnt + 1;
    if (ls_upd) ls_cnt <= ls_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected address of the slave, written as a number
  function automatic logic [6:0] bench_addr(input logic s);
    return 7'd22 + (s ? 7'd0 : 7'd1);
  endfunction

  task automatic wait_q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1; wait_q(1); m_scl = 1; wait_q(1);
    m_sda = 0; wait_q(1); m_scl = 0; wait_q(1);
  endtask

  task automatic bus_stop();
    m_scl = 0; wait_q(1); m_sda = 0; wait_q(1);
    m_scl = 1; wait_q(1); m_sda = 1; wait_q(2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_scl = 0; wait_q(1); m_sda = b[i]; wait_q(1);
      m_scl = 1; wait_q(2); m_scl = 0;
    end
  endtask

  // ninth clock: acked only if SDA is low through the high period
  task automatic ack_clock(output bit acked, output bit released);
    bit a0;
    wait_q(1); m_sda = 1; wait_q(1); m_scl = 1;
    wait_q(1); a0 = ~sda_line;
    wait_q(1); acked = a0 & ~sda_line;
    m_scl = 0; wait_q(1);
    released = ~sda_pull;
  endtask

  task automatic check_regs(input string tag);
    check(ms_byte == exp_ms, {tag, " ms_byte"}, ms_byte, exp_ms);
    check(ls_byte == exp_ls, {tag, " ls_byte"}, ls_byte, exp_ls);
    check(ms_cnt == exp_ms_cnt, {tag, " ms strobes"}, ms_cnt, exp_ms_cnt);
    check(ls_cnt == exp_ls_cnt, {tag, " ls strobes"}, ls_cnt, exp_ls_cnt);
  endtask

  task automatic write_word(input logic [6:0] addr, input logic rw,
                            input logic [7:0] ms, input logic [7:0] ls,
                            input int n_extra);
    bit acked, rel, hit;
    hit = (addr == bench_addr(strap)) && !rw;
    bus_start();
    send_bits({addr, rw}, 8);
    ack_clock(acked, rel);
    check(acked == hit, hit ? "R2 address ack" : "R3 address nack", acked, hit);
    check(rel, "R4 release after ninth clock", rel, 1);
    if (!acked) begin
      send_bits(ms, 8);  // ignored traffic
      ack_clock(acked, rel);
      check(!acked, "R3 ignored byte nack", acked, 0);
      bus_stop();
      check_regs("R3");
      return;
    end
    send_bits(ms, 8);
    ack_clock(acked, rel);
    exp_ms = ms; exp_ms_cnt++;
    check(acked, "R5 ms ack", acked, 1);
    check(ms_byte == exp_ms && ms_cnt == exp_ms_cnt, "R5 ms latched at ack", ms_byte, exp_ms);
    send_bits(ls, 8);
    ack_clock(acked, rel);
    exp_ls = ls; exp_ls_cnt++;
    check(acked, "R6 ls ack", acked, 1);
    check(rel, "R4 release after ls ack", rel, 1);
    for (int k = 0; k < n_extra; k++) begin
      send_bits(8'($urandom), 8);
      ack_clock(acked, rel);
      check(!acked, "R8 extra byte nack", acked, 0);
    end
    bus_stop();
    check_regs("R6 R8");
  endtask

  initial begin
    bit acked, rel;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    rst_n = 1;
    wait_q(2);
    // R9 reset state
    check(ms_byte == 0 && ls_byte == 0, "R9 reset bytes", {ms_byte, ls_byte}, 0);
    check(!sda_pull && !ms_upd && !ls_upd, "R9 reset outputs", sda_pull, 0);

    // R2 both strap settings, R10 bit order
    strap = 0; write_word(7'b0010111, 0, 8'h80, 8'h01, 0);
    check(ms_byte == 8'h80 && ls_byte == 8'h01, "R10 msb first", {ms_byte, ls_byte}, 16'h8001);
    strap = 1; write_word(7'b0010110, 0, 8'hA5, 8'h3C, 0);
    write_word(7'b0010111, 0, 8'h11, 8'h22, 0);  // wrong for strap 1
    // R3 read request
    write_word(7'b0010110, 1, 8'h44, 8'h55, 0);
    // R8 trailing bytes
    write_word(7'b0010110, 0, 8'hC3, 8'h5A, 2);

    // R7 STOP inside LS byte
    bus_start(); send_bits({7'b0010110, 1'b0}, 8); ack_clock(acked, rel);
    send_bits(8'h9E, 8); ack_clock(acked, rel);
    exp_ms = 8'h9E; exp_ms_cnt++;
    send_bits(8'h77, 5); bus_stop();
    check_regs("R7 stop mid byte");

    // R1 R7 repeated START inside MS byte, then a full word
    bus_start(); send_bits({7'b0010110, 1'b0}, 8); ack_clock(acked, rel);
    send_bits(8'hF0, 3);
    check_regs("R7 before restart");
    write_word(7'b0010110, 0, 8'h6D, 8'hB2, 0);
    check(ms_byte == 8'h6D, "R1 restart resumes address", ms_byte, 8'h6D);

    // random traffic
    for (int t = 0; t < 36; t++) begin
      logic [6:0] a;
      strap = 1'($urandom);
      a = ($urandom_range(0, 3) != 0) ? bench_addr(strap) : 7'($urandom);
      write_word(a, ($urandom_range(0, 4) == 0), 8'($urandom), 8'($urandom),
                 $urandom_range(0, 2));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule